// File: doc/BRIEF.md
# Cascadable Presettable Synchronous Counter

This block is a 4-bit synchronous binary up-counter. Every state change happens on the rising clock edge. Three synchronous controls act on the count, and each one overrides the next:

- a clear, active low;
- a parallel load from a data bus, active low;
- counting, which needs two count enables to be high at once.

When all controls are idle, the count holds its value.

The block has a carry output that goes high when the count is all ones, but only while the second enable is high. The first enable has no effect on it. The carry of one stage can drive the second enable of the next stage. A chain of stages then forms a wider counter with look-ahead carry. All stages share the clock, clear, load and first enable.

An active-low asynchronous reset places the register in a known state at power-up.

Top module: `casc_counter`

## Requirements
- R1: While `rst_ni` is low, `count_o` is 0 and `carry_o` is 0.
- R2: On a rising edge with `clr_ni` low, `count_o` becomes 0 whatever the levels on `load_ni`, `en_p_i`, `en_t_i` and `data_i`.
- R3: On a rising edge with `clr_ni` high and `load_ni` low, `count_o` takes the value of `data_i` whatever the levels on `en_p_i` and `en_t_i`.
- R4: On a rising edge with `clr_ni`, `load_ni`, `en_p_i` and `en_t_i` all high, `count_o` increments by one, wrapping from 15 to 0.
- R5: On a rising edge with `clr_ni` and `load_ni` high and either enable low, `count_o` keeps its value.
- R6: `carry_o` is high exactly when `count_o` is 15 (binary 1111) and `en_t_i` is high. It follows a change of `en_t_i` in the same cycle and does not depend on `en_p_i`.
- R7: Two stages form an 8-bit counter that counts 0 to 255 and wraps to 0 when connected as follows:
  - the low stage's `carry_o` drives the high stage's `en_t_i`;
  - the low stage's `en_t_i` and both stages' `en_p_i` are tied to a common enable.

  The high stage's `carry_o` is high only at 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; all state updates on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_ni | input | 1 | Synchronous clear, active low, highest priority |
| load_ni | input | 1 | Synchronous parallel load, active low |
| en_p_i | input | 1 | Count enable that does not reach the carry |
| en_t_i | input | 1 | Count enable that also gates the carry |
| data_i | input | WIDTH | Parallel load value |
| count_o | output | WIDTH | Current count |
| carry_o | output | 1 | Terminal count: all ones and `en_t_i` high |

## Verification
A wrong priority decode or a faulty incrementer shows at `count_o` on the first rising edge after the offending control pattern. Because the count is the entire state, every error surfaces within one cycle. A carry that is wrongly gated or tied to the first enable shows at `carry_o` at once, in the same cycle as the change in count or enable. In a chain, that fault appears as the high stage stepping too early or too late, which the 8-bit sequence check detects.

// File: rtl/cnt_pkg.sv
package cnt_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_INC   = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } cnt_op_e;
endpackage

// File: rtl/cnt_ctrl.sv
module cnt_ctrl
  import cnt_pkg::*;
(
  input  logic    clr_ni,
  input  logic    load_ni,
  input  logic    en_p_i,
  input  logic    en_t_i,
  output cnt_op_e op_o
);
  // clear > load > count > hold
  always_comb begin
    if (!clr_ni)              op_o = OP_CLEAR;
    else if (!load_ni)        op_o = OP_LOAD;
    else if (en_p_i && en_t_i) op_o = OP_INC;
    else                      op_o = OP_HOLD;
  end
endmodule

// File: rtl/cnt_next.sv
module cnt_next
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur_i,
  input  logic [WIDTH-1:0] data_i,
  input  cnt_op_e          op_i,
  output logic [WIDTH-1:0] nxt_o
);
  logic [WIDTH:0]   run;
  logic [WIDTH-1:0] inc;

  assign run[0] = 1'b1;
  // look-ahead toggle: bit i flips when all lower bits are ones
  for (genvar i = 0; i < WIDTH; i++) begin : g_inc
    assign inc[i]   = cur_i[i] ^ run[i];
    assign run[i+1] = run[i] & cur_i[i];
  end

  always_comb begin
    unique case (op_i)
      OP_CLEAR: nxt_o = '0;
      OP_LOAD:  nxt_o = data_i;
      OP_INC:   nxt_o = inc;
      default:  nxt_o = cur_i;
    endcase
  end
endmodule

// File: rtl/cnt_carry.sv
module cnt_carry #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cnt_i,
  input  logic             en_t_i,
  output logic             tc_o
);
  logic [WIDTH:0] ones;

  assign ones[0] = en_t_i;
  for (genvar i = 0; i < WIDTH; i++) begin : g_and
    assign ones[i+1] = ones[i] & cnt_i[i];
  end
  assign tc_o = ones[WIDTH];
endmodule

// File: rtl/casc_counter.sv
module casc_counter
  import cnt_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_ni,
  input  logic             load_ni,
  input  logic             en_p_i,
  input  logic             en_t_i,
  input  logic [WIDTH-1:0] data_i,
  output logic [WIDTH-1:0] count_o,
  output logic             carry_o
);
  cnt_op_e          op;
  logic [WIDTH-1:0] cnt_q, cnt_d;

  cnt_ctrl u_ctrl (
    .clr_ni (clr_ni),
    .load_ni(load_ni),
    .en_p_i (en_p_i),
    .en_t_i (en_t_i),
    .op_o   (op)
  );

  cnt_next #(.WIDTH(WIDTH)) u_next (
    .cur_i (cnt_q),
    .data_i(data_i),
    .op_i  (op),
    .nxt_o (cnt_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  cnt_carry #(.WIDTH(WIDTH)) u_carry (
    .cnt_i (cnt_q),
    .en_t_i(en_t_i),
    .tc_o  (carry_o)
  );

  assign count_o = cnt_q;
endmodule

// File: rtl/cnt_checker.sv
module cnt_checker #(
  parameter int WIDTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             clr_ni,
  input logic             load_ni,
  input logic             en_p_i,
  input logic             en_t_i,
  input logic [WIDTH-1:0] data_i,
  input logic [WIDTH-1:0] count_o,
  input logic             carry_o
);
  always_comb begin
    if (!rst_ni) AST_RESET_ZERO: assert (count_o == '0 && !carry_o); // R1
  end

  AST_CLEAR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |=> count_o == '0); // R2

  AST_LOAD_OVER_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && !load_ni) |=> count_o == $past(data_i)); // R3

  AST_STEP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && load_ni && en_p_i && en_t_i) |=> count_o == $past(count_o) + WIDTH'(1)); // R4

  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ni && load_ni && !(en_p_i && en_t_i)) |=> $stable(count_o)); // R5

  AST_CARRY_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    carry_o == ((&count_o) && en_t_i)); // R6
endmodule

bind casc_counter cnt_checker #(.WIDTH(WIDTH)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .clr_ni (clr_ni),
  .load_ni(load_ni),
  .en_p_i (en_p_i),
  .en_t_i (en_t_i),
  .data_i (data_i),
  .count_o(count_o),
  .carry_o(carry_o)
);

// File: tb/sim_casc_counter.sv
module sim_casc_counter;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_n, load_n, en_p, en_t;
  logic [W-1:0] data;
  logic [W-1:0] cnt;
  logic         carry;

  logic         c_clr_n, c_en;
  logic [W-1:0] lo_cnt, hi_cnt;
  logic         lo_carry, hi_carry;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [W-1:0] exp_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  casc_counter #(.WIDTH(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(clr_n), .load_ni(load_n),
    .en_p_i(en_p), .en_t_i(en_t), .data_i(data),
    .count_o(cnt), .carry_o(carry)
  );

  casc_counter #(.WIDTH(W)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(c_clr_n), .load_ni(1'b1),
    .en_p_i(c_en), .en_t_i(c_en), .data_i('0),
    .count_o(lo_cnt), .carry_o(lo_carry)
  );

  casc_counter #(.WIDTH(W)) u2 (
    .clk_i(clk), .rst_ni(rst_n), .clr_ni(c_clr_n), .load_ni(1'b1),
    .en_p_i(c_en), .en_t_i(lo_carry), .data_i('0),
    .count_o(hi_cnt), .carry_o(hi_carry)
  );

  function automatic logic [W-1:0] model_next(logic [W-1:0] cur, logic c, logic l,
                                              logic p, logic t, logic [W-1:0] d);
    if (!c)         return '0;
    if (!l)         return d;
    if (p && t)     return cur + W'(1);
    return cur;
  endfunction

  function automatic logic model_carry(logic [W-1:0] cur, logic t);
    return (cur == {W{1'b1}}) && t;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string tag_of(logic c, logic l, logic p, logic t);
    if (!c) return "R2";
    if (!l) return "R3";
    if (p && t) return "R4";
    return "R5";
  endfunction

  // called just after a falling edge
  task automatic step(logic c, logic l, logic p, logic t, logic [W-1:0] d);
    clr_n = c; load_n = l; en_p = p; en_t = t; data = d;
    #1;
    check(carry === model_carry(exp_cnt, t), "R6", int'(carry), int'(model_carry(exp_cnt, t)));
    @(posedge clk);
    exp_cnt = model_next(exp_cnt, c, l, p, t, d);
    @(negedge clk);
    check(cnt === exp_cnt, tag_of(c, l, p, t), int'(cnt), int'(exp_cnt));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed;
    clr_n = 1; load_n = 1; en_p = 1; en_t = 1; data = '0;
    c_clr_n = 1; c_en = 0;
    exp_cnt = '0;
    repeat (3) @(negedge clk);
    // R1: reset state with enables active
    check(cnt === '0, "R1", int'(cnt), 0);
    check(carry === 1'b0, "R1", int'(carry), 0);
    rst_n = 1'b1;

    // R3: load ignores enables being low
    step(1, 0, 0, 0, 4'd9);
    // R2: clear beats load and both enables
    step(0, 0, 1, 1, 4'd7);
    // R3: load beats counting
    step(1, 0, 1, 1, 4'd13);
    // R4: count 13 -> 14 -> 15 -> wrap 0
    step(1, 1, 1, 1, 4'd0);
    step(1, 1, 1, 1, 4'd0);
    // R6: at 15, en_t high and en_p low -> carry high; R5 hold
    step(1, 1, 0, 1, 4'd3);
    // R6: en_t low -> carry low even with en_p high; R5 hold
    step(1, 1, 1, 0, 4'd3);
    step(1, 1, 1, 1, 4'd0);
    check(cnt === 4'd0, "R4", int'(cnt), 0);
    // R5: both enables low
    step(1, 1, 0, 0, 4'd5);

    seed = 32'h5eed;
    void'($urandom(seed));
    for (int i = 0; i < 600; i++) begin
      logic [3:0] r;
      r = 4'($urandom);
      step(($urandom % 8) != 0, ($urandom % 6) != 0, r[0] | r[1], r[2] | r[3], 4'($urandom));
    end

    // R7: two-stage chain, 8-bit sequence with wrap
    c_clr_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    c_clr_n = 1'b1;
    c_en = 1'b1;
    for (int k = 1; k <= 300; k++) begin
      int e;
      #1;
      e = (k - 1) % 256;
      check(hi_carry === (e == 255), "R7", int'(hi_carry), int'(e == 255));
      @(posedge clk);
      @(negedge clk);
      e = k % 256;
      check({hi_cnt, lo_cnt} === 8'(e), "R7", int'({hi_cnt, lo_cnt}), e);
    end
    // R7: disabling the chain holds both stages
    c_en = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check({hi_cnt, lo_cnt} === 8'(300 % 256), "R7", int'({hi_cnt, lo_cnt}), 300 % 256);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule